// File: doc/BRIEF.md
# Nested Prioritized Event Controller

This block decides which of sixteen fixed-priority event levels a processor core services next, and it tracks the levels already in service so that handlers can nest. Level 0 has the highest priority. Seven levels are dedicated: debug entry (0), system reset (1), non-maskable (2), synchronous fault (3), an unused slot (4), hardware fault (5) and timer tick (6). Nine general-purpose levels follow (7 to 15).

Requests are latched in a pending bitmap. On every cycle the block looks at the latched requests together with the requests arriving that cycle and filters out the masked ones. It then compares the best candidate with the highest level still in service. When the candidate is strictly higher, a take strobe and a level index go to the core. In the same cycle the candidate moves from the pending bitmap to the in-service bitmap. The core signals the end of a handler with a one-cycle return pulse. That pulse drops the highest in-service level, so the level it preempted becomes current again.

Top module: `event_nest_ctl`

## Requirements
- R1: When `take` is high, `take_lvl` is the lowest-numbered level that is pending or requested this cycle and is enabled.
- R2: `take` rises only if the candidate level is numerically lower than every in-service level that remains after this cycle's return. A candidate that does not win stays in `pend_o`.
- R3: Nesting: a higher-priority event taken during service adds its bit to `act_o`, and the preempted levels keep their bits.
- R4: A request is eligible in the cycle it arrives. A synchronous fault (`fault_req`, level 3) raised while a general-purpose level is in service is taken in that same cycle.
- R5: Level 2 is requested by `wdog_nmi`, `pin_nmi` or `sw_nmi`, and each one works alone.
- R6: `sw_raise` with `sw_lvl` in 7..15 requests that level. Values 0..6 have no effect on `pend_o`, `act_o` or `take`.
- R7: Level 4 never appears in `pend_o`, `act_o` or `take_lvl`.
- R8: Bit k of `mask_din` enables level k+5. The value is written on `mask_we` and takes effect from the next cycle. After `rst_n` all maskable levels are disabled. A disabled level stays pending without being taken. Levels 0..3 ignore the mask.
- R9: On a take, the level's pending bit clears and its in-service bit sets at the next clock edge.
- R10: `ret_pulse` clears the lowest-numbered set bit of `act_o`. The take decision in that cycle already uses the reduced set.
- R11: `sys_rst_req` gives `take` with `take_lvl` = 1. It clears every pending bit and all other requests of that cycle, and the in-service bitmap becomes level 1 alone.
- R12: After `rst_n`, `pend_o` and `act_o` are zero and `take` is low while no request is present.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dbg_req | input | 1 | Level 0 request |
| sys_rst_req | input | 1 | Level 1 request, clears state |
| wdog_nmi | input | 1 | Level 2 source: watchdog |
| pin_nmi | input | 1 | Level 2 source: external pin |
| sw_nmi | input | 1 | Level 2 source: software |
| fault_req | input | 1 | Level 3 synchronous fault |
| hwerr_req | input | 1 | Level 5 hardware fault |
| tick_req | input | 1 | Level 6 timer tick |
| gp_req | input | LVLS-7 | Bit k requests level k+7 |
| sw_raise | input | 1 | Software raise strobe |
| sw_lvl | input | LW | Level for software raise |
| mask_we | input | 1 | Mask write strobe |
| mask_din | input | LVLS-5 | Bit k enables level k+5 |
| ret_pulse | input | 1 | Return-from-event |
| take | output | 1 | Event taken this cycle |
| take_lvl | output | LW | Level taken |
| pend_o | output | LVLS | Pending bitmap |
| act_o | output | LVLS | In-service bitmap |

## Verification
A return pulse and a take can fall in the same cycle. The bench provokes this by holding a lower-priority level pending under an active one and then pulsing `ret_pulse`. The reference model expects the pending level to be taken in that same cycle, with `act_o` showing only the new level afterwards. Fresh requests arriving together with a return, and the system-reset request colliding with pending and in-service state, are judged the same way against the model on every clock.

// File: rtl/event_nest_ctl.sv
module event_nest_ctl #(
  parameter int LVLS = 16,
  localparam int LW = $clog2(LVLS)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            dbg_req,
  input  logic            sys_rst_req,
  input  logic            wdog_nmi,
  input  logic            pin_nmi,
  input  logic            sw_nmi,
  input  logic            fault_req,
  input  logic            hwerr_req,
  input  logic            tick_req,
  input  logic [LVLS-8:0] gp_req,
  input  logic            sw_raise,
  input  logic [LW-1:0]   sw_lvl,
  input  logic            mask_we,
  input  logic [LVLS-6:0] mask_din,
  input  logic            ret_pulse,
  output logic            take,
  output logic [LW-1:0]   take_lvl,
  output logic [LVLS-1:0] pend_o,
  output logic [LVLS-1:0] act_o
);

  localparam int GP0 = 7;

  logic [LVLS-1:0] pend_q, act_q;
  logic [LVLS-6:0] mask_q;
  logic [LVLS-1:0] sw_vec, req, cand, allow, elig, p_oh, act_ret, a_oh, grant;
  logic            win;

  function automatic logic [LW-1:0] enc(input logic [LVLS-1:0] oh);
    enc = '0;
    for (int i = 0; i < LVLS; i++)
      if (oh[i]) enc = LW'(i);
  endfunction

  always_comb begin
    sw_vec = '0;
    if (sw_raise && sw_lvl >= LW'(GP0)) sw_vec[sw_lvl] = 1'b1;
  end

  assign req = {gp_req, tick_req, hwerr_req, 1'b0, fault_req,
                wdog_nmi | pin_nmi | sw_nmi, sys_rst_req, dbg_req} | sw_vec;

  assign cand    = pend_q | req;
  assign allow   = {mask_q, 5'b01111};
  assign elig    = cand & allow;
  assign p_oh    = elig & (~elig + 1'b1);
  assign act_ret = ret_pulse ? (act_q & (act_q - 1'b1)) : act_q;
  assign a_oh    = act_ret & (~act_ret + 1'b1);
  assign win     = (p_oh != '0) && ((a_oh == '0) || (p_oh < a_oh));
  assign grant   = win ? p_oh : '0;

  assign take     = sys_rst_req | win;
  assign take_lvl = sys_rst_req ? LW'(1) : enc(p_oh);
  assign pend_o   = pend_q;
  assign act_o    = act_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
      act_q  <= '0;
      mask_q <= '0;
    end else begin
      if (mask_we) mask_q <= mask_din;
      if (sys_rst_req) begin
        pend_q <= '0;
        act_q  <= LVLS'(2);
      end else begin
        pend_q <= cand & ~grant;
        act_q  <= act_ret | grant;
      end
    end
  end

endmodule

module event_nest_ctl_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        sys_rst_req,
  input logic        ret_pulse,
  input logic        take,
  input logic [3:0]  take_lvl,
  input logic [15:0] pend_o,
  input logic [15:0] act_o,
  input logic [10:0] mask_q
);

  a_r7_slot4_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !pend_o[4] && !act_o[4] && !(take && take_lvl == 4'd4));

  a_r9_take_enters_service: assert property (@(posedge clk) disable iff (!rst_n)
    take && !sys_rst_req |=> act_o[$past(take_lvl)] && !pend_o[$past(take_lvl)]);

  a_r11_reset_request: assert property (@(posedge clk) disable iff (!rst_n)
    sys_rst_req |=> act_o == 16'h0002 && pend_o == 16'h0000);

  a_r2_outranks_active: assert property (@(posedge clk) disable iff (!rst_n)
    take && !sys_rst_req && !ret_pulse |->
      (act_o & ((16'd1 << take_lvl) | ((16'd1 << take_lvl) - 16'd1))) == 16'd0);

  a_r10_return_drops_one: assert property (@(posedge clk) disable iff (!rst_n)
    ret_pulse && !take && !sys_rst_req && act_o != 16'd0 |=>
      $countones(act_o) == $countones($past(act_o)) - 1);

  a_r8_mask_honoured: assert property (@(posedge clk) disable iff (!rst_n)
    take && !sys_rst_req && take_lvl >= 4'd5 |-> mask_q[take_lvl - 4'd5]);

endmodule

bind event_nest_ctl event_nest_ctl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .sys_rst_req(sys_rst_req), .ret_pulse(ret_pulse),
  .take(take), .take_lvl(take_lvl), .pend_o(pend_o), .act_o(act_o), .mask_q(mask_q)
);

// File: tb/event_nest_ctl_test.sv
module event_nest_ctl_test;
  logic clk = 1'b0, rst_n = 1'b0;
  always #10 clk = ~clk;

  logic dbg, srst, wd, pn, sn, flt, hw, tk, swr, mwe, rfe;
  logic [8:0]  gp;
  logic [3:0]  swl;
  logic [10:0] mdin;
  logic n_dbg, n_srst, n_wd, n_pn, n_sn, n_flt, n_hw, n_tk, n_swr, n_mwe, n_rfe;
  logic [8:0]  n_gp;
  logic [3:0]  n_swl;
  logic [10:0] n_mdin;

  logic        take;
  logic [3:0]  take_lvl;
  logic [15:0] pend_o, act_o;

  event_nest_ctl uut (
    .clk(clk), .rst_n(rst_n), .dbg_req(dbg), .sys_rst_req(srst),
    .wdog_nmi(wd), .pin_nmi(pn), .sw_nmi(sn), .fault_req(flt),
    .hwerr_req(hw), .tick_req(tk), .gp_req(gp), .sw_raise(swr), .sw_lvl(swl),
    .mask_we(mwe), .mask_din(mdin), .ret_pulse(rfe),
    .take(take), .take_lvl(take_lvl), .pend_o(pend_o), .act_o(act_o));

  int checks = 0, failures = 0, cyc = 0;
  logic [15:0] m_pend = '0, m_act = '0;
  bit m_en [16];

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      failures++;
      $display("FAIL watchdog: actual=expired expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic chk(input string tag, input string what, input logic [15:0] a, input logic [15:0] e);
    checks++;
    if (a !== e) begin
      failures++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, a, e);
    end
  endtask

  task automatic clr();
    {n_dbg, n_srst, n_wd, n_pn, n_sn, n_flt, n_hw, n_tk, n_swr, n_mwe, n_rfe} = '0;
    n_gp = '0; n_swl = '0; n_mdin = '0;
  endtask

  task automatic step(input string tag);
    logic [15:0] r, ar;
    int best, top, el;
    bit et;
    @(negedge clk);
    {dbg, srst, wd, pn, sn, flt, hw, tk, swr, mwe, rfe} =
      {n_dbg, n_srst, n_wd, n_pn, n_sn, n_flt, n_hw, n_tk, n_swr, n_mwe, n_rfe};
    gp = n_gp; swl = n_swl; mdin = n_mdin;
    #5;
    r = '0;
    r[0] = dbg; r[1] = srst; r[2] = wd | pn | sn; r[3] = flt; r[5] = hw; r[6] = tk;
    for (int k = 0; k < 9; k++) r[7+k] = gp[k];
    if (swr && swl >= 7) r[swl] = 1'b1;
    ar = m_act;
    if (rfe) for (int i = 0; i < 16; i++) if (ar[i]) begin ar[i] = 1'b0; break; end
    best = -1;
    for (int i = 0; i < 16; i++)
      if ((m_pend[i] | r[i]) && i != 4 && (i < 4 || m_en[i])) begin best = i; break; end
    top = 16;
    for (int i = 0; i < 16; i++) if (ar[i]) begin top = i; break; end
    if (srst) begin et = 1; el = 1; end
    else begin et = (best >= 0) && (best < top); el = et ? best : 0; end
    chk(tag, "take", {15'd0, take}, {15'd0, et});
    if (et) chk(tag, "take_lvl", {12'd0, take_lvl}, 16'(el));
    chk(tag, "pend_o", pend_o, m_pend);
    chk(tag, "act_o", act_o, m_act);
    if (srst) begin m_pend = '0; m_act = 16'h0002; end
    else begin
      m_pend = m_pend | r; m_act = ar;
      if (et) begin m_pend[best] = 1'b0; m_act[best] = 1'b1; end
    end
    if (mwe) for (int k = 0; k < 11; k++) m_en[5+k] = mdin[k];
  endtask

  task automatic rets(input int n);
    for (int i = 0; i < n; i++) begin clr(); n_rfe = 1; step("R10"); end
    clr();
  endtask

  initial begin
    clr();
    {dbg, srst, wd, pn, sn, flt, hw, tk, swr, mwe, rfe} = '0;
    gp = '0; swl = '0; mdin = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    step("R12"); step("R12");

    // masked levels stay pending, unmaskable fault is taken
    n_gp = 9'h1FF; step("R8"); clr();
    n_hw = 1; step("R8"); clr();
    n_flt = 1; step("R4"); clr();
    rets(1);
    n_mwe = 1; n_mdin = 11'h7FF; step("R8"); clr();
    step("R1");
    step("R2");
    // return and take in the same cycle
    n_rfe = 1; step("R10"); clr();
    n_tk = 1; step("R3"); clr();
    n_flt = 1; step("R4"); clr();
    n_dbg = 1; step("R1"); clr();
    step("R3");
    rets(14);

    n_wd = 1; step("R5"); clr(); rets(1);
    n_pn = 1; step("R5"); clr(); rets(1);
    n_sn = 1; step("R5"); clr(); rets(1);

    n_swr = 1; n_swl = 4'd3; step("R6"); clr(); step("R6");
    n_swr = 1; n_swl = 4'd4; step("R7"); clr(); step("R7");
    n_swr = 1; n_swl = 4'd6; step("R6"); clr(); step("R6");
    n_swr = 1; n_swl = 4'd11; step("R6"); clr(); rets(1);

    // level-specific mask: only level 10 and 15 enabled
    n_mwe = 1; n_mdin = 11'b10000100000; step("R8"); clr();
    n_gp = 9'b000000110; step("R8"); clr();
    n_gp = 9'b100000000; step("R3"); clr();
    n_gp = 9'b000001000; step("R3"); clr();
    n_mwe = 1; n_mdin = 11'h7FF; step("R8"); clr();
    n_hw = 1; step("R3"); clr();
    step("R2");
    n_rfe = 1; n_tk = 1; step("R10"); clr();
    rets(8);

    n_gp = 9'h0F0; n_tk = 1; step("R11"); clr();
    n_srst = 1; n_dbg = 1; n_gp = 9'h003; step("R11"); clr();
    step("R11");
    rets(2);
    step("R12");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule